// File: doc/BRIEF.md
# Multi-Operation Reconfigurable Unit Stall Controller

This block sits beside a processor pipeline and controls a reconfigurable array that keeps several custom operations loaded at once. Each loaded operation lives in a slot and carries an operation-code tag. It also carries a mask of the register-file entries it reads and a combine function. The array holds shadow copies of the register file and evaluates every slot continuously. Each register has a settle counter that models how long the array logic takes to propagate a new value.

When the processor presents a custom operation, the controller looks up the tag. On a hit it holds the processor stalled until every register in that operation's mask has settled, then returns the matching slot's result. Only late-written inputs lengthen the wait. On a miss it stalls, asks an external loader to place the operation into a chosen slot, and repeats the lookup once the loader reports completion. The slot to replace is an empty slot first, otherwise the least recently used one.

Top module: `rfu_stall_ctrl`

## Requirements
- R1: After reset every slot is empty, `stall_o`, `done_o` and `reload_req_o` are low while `issue_i` is low, and the first issue of any code misses.
- R2: A hit whose masked registers are all settled completes in the issue cycle: `done_o` high and `stall_o` low in that same cycle.
- R3: The slot result combines its masked registers with the function loaded as `reload_fn_i`: 0 = sum modulo 2^DATA_W, 1 = XOR, 2 = OR, 3 = AND.
- R4: A write to register k puts k into an unsettled state for SETTLE cycles after the write cycle. A hit that reads k and is issued in the cycle after the write stalls exactly SETTLE cycles. A write in the issue cycle itself adds one more stall cycle.
- R5: Writes to registers outside the matched operation's mask do not delay its completion.
- R6: On a miss, `stall_o` is high in the issue cycle. From the next cycle `reload_req_o` stays high, with stable `reload_opc_o` and `reload_slot_o`, until `reload_done_i`. The lookup is repeated in the cycle after `reload_done_i`.
- R7: The reload slot is the lowest-index empty slot if one exists. Otherwise it is the slot whose last completion or load is oldest.
- R8: `done_o` is high only while `issue_i` is high and `stall_o` is low, and at most one slot matches any code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register file write strobe |
| wr_addr_i | input | $clog2(NUM_REGS) | Register written |
| wr_data_i | input | DATA_W | Value written |
| issue_i | input | 1 | Custom operation presented, held while stalled |
| issue_opc_i | input | OPC_W | Operation code presented |
| stall_o | output | 1 | Processor must hold the operation |
| done_o | output | 1 | Result valid this cycle |
| result_o | output | DATA_W | Result of the matching slot |
| reload_req_o | output | 1 | Request to load an operation |
| reload_opc_o | output | OPC_W | Code to load |
| reload_slot_o | output | $clog2(NUM_SLOTS) | Slot to overwrite |
| reload_done_i | input | 1 | Load finished, config present on the inputs below |
| reload_mask_i | input | NUM_REGS | Registers read by the loaded operation |
| reload_fn_i | input | 2 | Combine function of the loaded operation |

## Verification
A wrong settle counter shows up as a stall count that differs from SETTLE on the first issue after a write to a masked register. A corrupted tag or valid bit shows up as an unexpected `reload_req_o` one cycle after issue, or as a missing one. A broken recency order stays hidden until every slot is full. It then surfaces on the next miss as a wrong `reload_slot_o` and, on a later issue, as a reload of an operation that should still have been resident. The bench therefore fills all slots, reorders their use and forces two capacity misses.

// File: rtl/rfu_pkg.sv
package rfu_pkg;
  typedef enum logic [1:0] {
    FN_SUM = 2'd0,
    FN_XOR = 2'd1,
    FN_OR  = 2'd2,
    FN_AND = 2'd3
  } fn_e;

  typedef enum logic {
    ST_LOOKUP = 1'b0,
    ST_RELOAD = 1'b1
  } st_e;
endpackage

// File: rtl/rfu_settle_rf.sv
module rfu_settle_rf #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int SETTLE   = 3,
  localparam int AW = $clog2(NUM_REGS),
  localparam int CW = $clog2(SETTLE + 1)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               wr_en_i,
  input  logic [AW-1:0]                      wr_addr_i,
  input  logic [DATA_W-1:0]                  wr_data_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]    regs_o,
  output logic [NUM_REGS-1:0]                ready_o
);
  logic [NUM_REGS-1:0][CW-1:0] cnt_q;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_o[r] <= '0;
        cnt_q[r]  <= '0;
      end else if (wr_en_i && wr_addr_i == AW'(r)) begin
        regs_o[r] <= wr_data_i;
        cnt_q[r]  <= CW'(SETTLE);
      end else if (cnt_q[r] != '0) begin
        cnt_q[r]  <= cnt_q[r] - 1'b1;
      end
    end
    assign ready_o[r] = (cnt_q[r] == '0);
  end

  if (SETTLE > 0) begin : g_settle_chk
    // R4
    write_unsettles_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> !ready_o[$past(wr_addr_i)]);
  end
endmodule

// File: rtl/rfu_op_row.sv
module rfu_op_row
  import rfu_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int OPC_W    = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            load_i,
  input  logic [OPC_W-1:0]                load_opc_i,
  input  logic [NUM_REGS-1:0]             load_mask_i,
  input  fn_e                             load_fn_i,
  input  logic [OPC_W-1:0]                opc_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  output logic                            valid_o,
  output logic                            hit_o,
  output logic [NUM_REGS-1:0]             mask_o,
  output logic [DATA_W-1:0]               value_o
);
  logic [OPC_W-1:0] tag_q;
  fn_e              fn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      tag_q   <= '0;
      mask_o  <= '0;
      fn_q    <= FN_SUM;
    end else if (load_i) begin
      valid_o <= 1'b1;
      tag_q   <= load_opc_i;
      mask_o  <= load_mask_i;
      fn_q    <= load_fn_i;
    end
  end

  assign hit_o = valid_o && (tag_q == opc_i);

  // Row evaluates continuously from the shadow registers.
  always_comb begin
    value_o = (fn_q == FN_AND) ? '1 : '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (mask_o[r]) begin
        unique case (fn_q)
          FN_SUM: value_o = value_o + regs_i[r];
          FN_XOR: value_o = value_o ^ regs_i[r];
          FN_OR:  value_o = value_o | regs_i[r];
          FN_AND: value_o = value_o & regs_i[r];
        endcase
      end
    end
  end
endmodule

// File: rtl/rfu_lru.sv
module rfu_lru #(
  parameter int NUM_SLOTS = 4,
  localparam int SW = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 touch_i,
  input  logic [SW-1:0]        touch_slot_i,
  input  logic [NUM_SLOTS-1:0] valid_i,
  output logic [SW-1:0]        victim_o
);
  logic [NUM_SLOTS-1:0][SW-1:0] rank_q;
  logic [NUM_SLOTS-1:0]         oldest;
  logic [SW-1:0]                touch_rank;

  assign touch_rank = rank_q[touch_slot_i];

  // rank 0 = most recent, NUM_SLOTS-1 = least recent
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_rank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rank_q[s] <= SW'(s);
      end else if (touch_i) begin
        if (touch_slot_i == SW'(s))       rank_q[s] <= '0;
        else if (rank_q[s] < touch_rank) rank_q[s] <= rank_q[s] + 1'b1;
      end
    end
    assign oldest[s] = (rank_q[s] == SW'(NUM_SLOTS - 1));
  end

  always_comb begin
    victim_o = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (oldest[s]) victim_o = SW'(s);
    end
    if (!(&valid_i)) begin
      for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
        if (!valid_i[s]) victim_o = SW'(s);
      end
    end
  end

  // R7
  lru_perm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(oldest) == 1);
endmodule

// File: rtl/rfu_stall_ctrl.sv
module rfu_stall_ctrl
  import rfu_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int DATA_W    = 16,
  parameter int OPC_W     = 4,
  parameter int NUM_SLOTS = 4,
  parameter int SETTLE    = 3,
  localparam int AW = $clog2(NUM_REGS),
  localparam int SW = $clog2(NUM_SLOTS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                issue_i,
  input  logic [OPC_W-1:0]    issue_opc_i,
  output logic                stall_o,
  output logic                done_o,
  output logic [DATA_W-1:0]   result_o,
  output logic                reload_req_o,
  output logic [OPC_W-1:0]    reload_opc_o,
  output logic [SW-1:0]       reload_slot_o,
  input  logic                reload_done_i,
  input  logic [NUM_REGS-1:0] reload_mask_i,
  input  logic [1:0]          reload_fn_i
);
  st_e                               state_q;
  logic [NUM_REGS-1:0][DATA_W-1:0]   regs;
  logic [NUM_REGS-1:0]               reg_ready;
  logic [NUM_SLOTS-1:0]              slot_valid;
  logic [NUM_SLOTS-1:0]              slot_hit;
  logic [NUM_SLOTS-1:0][NUM_REGS-1:0] slot_mask;
  logic [NUM_SLOTS-1:0][DATA_W-1:0]  slot_value;
  logic [SW-1:0]                     victim;
  logic [SW-1:0]                     hit_idx;
  logic                              any_hit;
  logic                              operands_ready;
  logic                              wr_conflict;
  logic                              load_fire;
  logic                              touch;
  logic [SW-1:0]                     touch_slot;

  rfu_settle_rf #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .SETTLE(SETTLE)) u_rf (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .regs_o(regs), .ready_o(reg_ready)
  );

  assign load_fire = (state_q == ST_RELOAD) && reload_done_i;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_row
    rfu_op_row #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .OPC_W(OPC_W)) u_row (
      .clk_i, .rst_ni,
      .load_i      (load_fire && reload_slot_o == SW'(s)),
      .load_opc_i  (reload_opc_o),
      .load_mask_i (reload_mask_i),
      .load_fn_i   (fn_e'(reload_fn_i)),
      .opc_i       (issue_opc_i),
      .regs_i      (regs),
      .valid_o     (slot_valid[s]),
      .hit_o       (slot_hit[s]),
      .mask_o      (slot_mask[s]),
      .value_o     (slot_value[s])
    );
  end

  always_comb begin
    hit_idx = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (slot_hit[s]) hit_idx = SW'(s);
    end
  end

  assign any_hit        = |slot_hit;
  assign wr_conflict    = wr_en_i && slot_mask[hit_idx][wr_addr_i];
  assign operands_ready = ((slot_mask[hit_idx] & ~reg_ready) == '0) && !wr_conflict;

  assign done_o   = (state_q == ST_LOOKUP) && issue_i && any_hit && operands_ready;
  assign stall_o  = (state_q == ST_RELOAD) || (issue_i && !done_o);
  assign result_o = slot_value[hit_idx];
  assign reload_req_o = (state_q == ST_RELOAD);

  assign touch      = done_o || load_fire;
  assign touch_slot = load_fire ? reload_slot_o : hit_idx;

  rfu_lru #(.NUM_SLOTS(NUM_SLOTS)) u_lru (
    .clk_i, .rst_ni,
    .touch_i      (touch),
    .touch_slot_i (touch_slot),
    .valid_i      (slot_valid),
    .victim_o     (victim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_LOOKUP;
      reload_opc_o  <= '0;
      reload_slot_o <= '0;
    end else begin
      unique case (state_q)
        ST_LOOKUP: if (issue_i && !any_hit) begin
          state_q       <= ST_RELOAD;
          reload_opc_o  <= issue_opc_i;
          reload_slot_o <= victim;
        end
        ST_RELOAD: if (reload_done_i) state_q <= ST_LOOKUP;
      endcase
    end
  end

  // R8
  tag_unique_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slot_hit));
  // R8
  done_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (issue_i && !stall_o));
  // R6
  reload_stalls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_req_o |-> stall_o);
  // R6
  reload_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_req_o && !reload_done_i) |=>
      (reload_req_o && $stable(reload_opc_o) && $stable(reload_slot_o)));
  // R6
  miss_to_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reload_req_o && issue_i && !any_hit) |=> reload_req_o);
endmodule

// File: tb/rfu_stall_ctrl_bench.sv
module rfu_stall_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 8, DW = 16, OW = 4, NS = 4, SETTLE = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0; logic [2:0] wr_addr = '0; logic [DW-1:0] wr_data = '0;
  logic issue = 0; logic [OW-1:0] opc = '0;
  logic stall, done, req, rdone = 0;
  logic [DW-1:0] result;
  logic [OW-1:0] ropc; logic [1:0] rslot;
  logic [NR-1:0] rmask = '0; logic [1:0] rfn = '0;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [DW-1:0] model [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  rfu_stall_ctrl #(.NUM_REGS(NR), .DATA_W(DW), .OPC_W(OW), .NUM_SLOTS(NS),
                   .SETTLE(SETTLE)) u_rfu_stall_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .issue_i(issue), .issue_opc_i(opc), .stall_o(stall),
    .done_o(done), .result_o(result), .reload_req_o(req), .reload_opc_o(ropc),
    .reload_slot_o(rslot), .reload_done_i(rdone), .reload_mask_i(rmask),
    .reload_fn_i(rfn));

  task automatic chk(input bit ok, input string req_tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] eval(input logic [NR-1:0] m, input logic [1:0] f);
    logic [DW-1:0] a = (f == 2'd3) ? '1 : '0;
    for (int r = 0; r < NR; r++) if (m[r])
      case (f)
        2'd0: a = a + model[r];
        2'd1: a = a ^ model[r];
        2'd2: a = a | model[r];
        default: a = a & model[r];
      endcase
    return a;
  endfunction

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk); wr_en = 0; model[a] = d;
  endtask

  // Issue a resident op, count stall cycles until done. Called at a negedge.
  task automatic run_hit(input logic [OW-1:0] o, input logic [NR-1:0] m,
                         input logic [1:0] f, input int exp_stall, input string tag);
    int stalls = 0;
    issue = 1; opc = o;
    for (int i = 0; i < 20; i++) begin
      #1;
      if (done) break;
      chk(stall && !req, tag, {stall, req}, 2'b10);
      stalls++;
      @(negedge clk);
    end
    chk(done && !stall, {tag, " done"}, {done, stall}, 2'b10);
    chk(stalls == exp_stall, {tag, " stall cycles"}, stalls, exp_stall);
    chk(result == eval(m, f), {tag, " result"}, result, eval(m, f));
    @(negedge clk); issue = 0;
  endtask

  // Issue a missing op, answer the reload, then expect completion.
  task automatic run_miss(input logic [OW-1:0] o, input logic [NR-1:0] m,
                          input logic [1:0] f, input int exp_slot, input string tag);
    @(negedge clk); issue = 1; opc = o;
    #1 chk(stall && !done && !req, {tag, " R6 miss stall"}, {stall, done, req}, 3'b100);
    @(negedge clk); #1;
    chk(req && ropc == o, {tag, " R6 req"}, {req, ropc}, {1'b1, o});
    chk(rslot == 2'(exp_slot), {tag, " R7 slot"}, rslot, exp_slot);
    @(negedge clk); #1;
    chk(req && stall && rslot == 2'(exp_slot), {tag, " R6 hold"}, {req, stall}, 2'b11);
    @(negedge clk); rdone = 1; rmask = m; rfn = f;
    @(negedge clk); rdone = 0;
    #1 chk(done && !stall && !req, {tag, " R6 retry"}, {done, stall, req}, 3'b100);
    chk(result == eval(m, f), {tag, " R3 result"}, result, eval(m, f));
    @(negedge clk); issue = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!stall && !done && !req, "R1 idle outputs", {stall, done, req}, 3'b000);
  endtask

  task automatic t_fill();
    logic [DW-1:0] init [NR] = '{16'h1234, 16'h00F0, 16'h8001, 16'h0F0F,
                                 16'hFFFF, 16'h0003, 16'h5A5A, 16'h7000};
    for (int r = 0; r < NR; r++) wr(r, init[r]);
    repeat (SETTLE + 1) @(negedge clk);
    // R1 R7 empty slots fill in index order; R3 all four functions
    run_miss(4'd1, 8'b0000_0111, 2'd0, 0, "R1 A sum");
    run_miss(4'd2, 8'b0001_1000, 2'd1, 1, "R7 B xor");
    run_miss(4'd3, 8'b0110_0000, 2'd2, 2, "R7 C or");
    run_miss(4'd4, 8'b1001_0001, 2'd3, 3, "R7 D and");
  endtask

  task automatic t_settled_hit();
    @(negedge clk);
    run_hit(4'd1, 8'b0000_0111, 2'd0, 0, "R2 settled hit");
  endtask

  task automatic t_late_input();
    wr(1, 16'h4321);
    run_hit(4'd1, 8'b0000_0111, 2'd0, SETTLE, "R4 late input");
  endtask

  task automatic t_unmasked_write();
    wr(7, 16'h0101);
    run_hit(4'd1, 8'b0000_0111, 2'd0, 0, "R5 unmasked write");
  endtask

  task automatic t_same_cycle_write();
    @(negedge clk);
    issue = 1; opc = 4'd1; wr_en = 1; wr_addr = 3'd0; wr_data = 16'h0042;
    #1 chk(stall && !done, "R4 write in issue cycle", {stall, done}, 2'b10);
    @(negedge clk); wr_en = 0; model[0] = 16'h0042;
    run_hit(4'd1, 8'b0000_0111, 2'd0, SETTLE, "R4 after same-cycle write");
  endtask

  task automatic t_lru();
    // recency now: A(0) D(3) C(2) B(1) -> victim slot 1
    run_miss(4'd9, 8'b0010_0010, 2'd0, 1, "R7 evict oldest");
    // recency: E(1) A(0) D(3) C(2) -> B was evicted, victim slot 2
    run_miss(4'd2, 8'b0001_1000, 2'd1, 2, "R7 reload evicted");
    @(negedge clk);
    run_hit(4'd9, 8'b0010_0010, 2'd0, 0, "R7 E still resident");
  endtask

  task automatic t_no_issue();
    @(negedge clk); #1;
    chk(!done && !stall, "R8 no issue no done", {done, stall}, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fill();
    t_settled_hit();
    t_late_input();
    t_unmasked_write();
    t_same_cycle_write();
    t_lru();
    t_no_issue();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule